// File: doc/BRIEF.md
# Dual-Loop Lock Detector

This block watches two frequency-synthesizer loops and tells the outside world, on a single pin, whether both are settled. For each loop it receives the pulse train of the reference divider and the pulse train of the feedback divider, pairs their rising edges and judges every pair against a fixed coincidence window. A loop is declared locked only after an uninterrupted run of in-window comparisons has lasted a per-loop qualification time. The loop with the faster comparison rate gets the shorter time. A single out-of-window comparison drops the lock at once.

Each loop has an active-high run input. Driving it low puts the loop in power save. While it is low the loop always reports locked and its detector state is discarded, so after wake-up the lock must be earned again from zero. At power-up the run inputs are expected to stay low until both loops have been programmed. The pin carries the AND of both loop verdicts. A test mode replaces the verdict with the raw output of one of the four dividers.

All inputs are synchronous to `clk`. Window and qualification lengths are given in clock cycles.

Top module: `pll_pair_lock_detect`

## Requirements
- R1: With test mode off, `lockOut` is high only when each loop is either locked or in power save.
- R2: A rising edge of one divider pulse, followed by a rising edge of the other pulse of the same loop no more than `WINDOW_CYC` cycles later, is an in-window comparison. Two edges in the same cycle are also an in-window comparison.
- R3: When the partner edge has not arrived `WINDOW_CYC` cycles after the first edge, the comparison is out of window, whichever pulse leads. An out-of-window comparison clears that loop's lock, and `lockOut` falls two cycles after the cycle in which the deciding edge was sampled.
- R4: A loop becomes locked at an in-window comparison that occurs at least `QUAL_L1_CYC` (loop 1) or `QUAL_L2_CYC` (loop 2) cycles after the first in-window comparison of its current run. The run starts at the first in-window comparison after reset, after a failure or after power save.
- R5: A second edge of the leading pulse, seen before the partner edge has arrived, is an out-of-window comparison. The new edge then starts a new wait.
- R6: When a loop's run input is low, that loop counts as locked at `lockOut` from the next clock edge. Its run, lock and pending edge are discarded, so after the input returns high the loop is unlocked until R4 is met again.
- R7: With `testEn` high, `lockOut` follows one clock later the divider pulse chosen by `testSel`: 2'b00 loop-2 reference, 2'b01 loop-2 feedback, 2'b10 loop-1 reference, 2'b11 loop-1 feedback.
- R8: During reset `lockOut` is low, and both loops are unlocked with no run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| loop1Ref | input | 1 | Loop-1 reference divider pulse |
| loop1Fb | input | 1 | Loop-1 feedback divider pulse |
| loop1Run | input | 1 | Loop-1 operating (high) or power save (low) |
| loop2Ref | input | 1 | Loop-2 reference divider pulse |
| loop2Fb | input | 1 | Loop-2 feedback divider pulse |
| loop2Run | input | 1 | Loop-2 operating (high) or power save (low) |
| testEn | input | 1 | Route a divider pulse to `lockOut` |
| testSel | input | 2 | Divider chosen in test mode |
| lockOut | output | 1 | Registered combined lock verdict or test pulse |

## Verification
A pulse edge sampled at one rising clock edge is turned into a comparison strobe at that edge. The strobe reaches the loop's lock state at the next edge and `lockOut` at the edge after that. Power-save and test-mode effects appear after a single edge. The bench keeps a port-level reference model that steps through the same three stages at every rising edge, and compares `lockOut` with it at each falling edge. The directed checks are placed many cycles away from any expected change, so they do not depend on the exact cycle of a transition.

// File: rtl/pll_lockdet_pkg.sv
package pll_lockdet_pkg;

  // Verdict of one edge pairing, raised for a single cycle
  typedef struct packed {
    logic inWin;
    logic outWin;
  } cmpStrobe_t;

  typedef enum logic [1:0] {
    PAIR_IDLE     = 2'd0,
    PAIR_WAIT_FB  = 2'd1,
    PAIR_WAIT_REF = 2'd2
  } pairState_t;

  // Test-route selector codes
  localparam logic [1:0] SEL_L2_REF = 2'b00;
  localparam logic [1:0] SEL_L2_FB  = 2'b01;
  localparam logic [1:0] SEL_L1_REF = 2'b10;
  localparam logic [1:0] SEL_L1_FB  = 2'b11;

endpackage

// File: rtl/lock_window_ctrl.sv
module lock_window_ctrl
  import pll_lockdet_pkg::*;
#(
  parameter int WINDOW_CYC = 26
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loopRun,
  input  logic       refPulse,
  input  logic       fbPulse,
  output cmpStrobe_t strobe
);

  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WINDOW_CYC);

  logic refQ, fbQ;
  logic refEdge, fbEdge;
  pairState_t state, stateNxt;
  logic [CW-1:0] gapCnt, gapCntNxt;
  logic passNxt, failNxt;

  assign refEdge = refPulse & ~refQ;
  assign fbEdge  = fbPulse & ~fbQ;

  always_comb begin
    stateNxt  = state;
    gapCntNxt = gapCnt;
    passNxt   = 1'b0;
    failNxt   = 1'b0;
    unique case (state)
      PAIR_IDLE: begin
        if (refEdge && fbEdge) begin
          passNxt = 1'b1;
        end else if (refEdge) begin
          stateNxt  = PAIR_WAIT_FB;
          gapCntNxt = CW'(1);
        end else if (fbEdge) begin
          stateNxt  = PAIR_WAIT_REF;
          gapCntNxt = CW'(1);
        end
      end
      PAIR_WAIT_FB: begin
        if (fbEdge) begin
          passNxt   = 1'b1;
          stateNxt  = refEdge ? PAIR_WAIT_FB : PAIR_IDLE;
          gapCntNxt = CW'(1);
        end else if (refEdge) begin
          failNxt   = 1'b1;
          gapCntNxt = CW'(1);
        end else if (gapCnt == WIN_LAST) begin
          failNxt  = 1'b1;
          stateNxt = PAIR_IDLE;
        end else begin
          gapCntNxt = gapCnt + CW'(1);
        end
      end
      PAIR_WAIT_REF: begin
        if (refEdge) begin
          passNxt   = 1'b1;
          stateNxt  = fbEdge ? PAIR_WAIT_REF : PAIR_IDLE;
          gapCntNxt = CW'(1);
        end else if (fbEdge) begin
          failNxt   = 1'b1;
          gapCntNxt = CW'(1);
        end else if (gapCnt == WIN_LAST) begin
          failNxt  = 1'b1;
          stateNxt = PAIR_IDLE;
        end else begin
          gapCntNxt = gapCnt + CW'(1);
        end
      end
      default: stateNxt = PAIR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ <= 1'b0;
      fbQ  <= 1'b0;
    end else begin
      refQ <= refPulse;
      fbQ  <= fbPulse;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !loopRun) begin
      state        <= PAIR_IDLE;
      gapCnt       <= '0;
      strobe.inWin  <= 1'b0;
      strobe.outWin <= 1'b0;
    end else begin
      state        <= stateNxt;
      gapCnt       <= gapCntNxt;
      strobe.inWin  <= passNxt;
      strobe.outWin <= failNxt;
    end
  end

endmodule

// File: rtl/lock_qual_path.sv
module lock_qual_path
  import pll_lockdet_pkg::*;
#(
  parameter int QUAL_L1_CYC = 412,
  parameter int QUAL_L2_CYC = 2500
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmpStrobe_t [1:0] loopStrobe,
  input  logic [1:0]       loopRun,
  input  logic [1:0]       refPulse,
  input  logic [1:0]       fbPulse,
  input  logic             testEn,
  input  logic [1:0]       testSel,
  output logic             lockOut
);

  localparam int QMAX = (QUAL_L1_CYC > QUAL_L2_CYC) ? QUAL_L1_CYC : QUAL_L2_CYC;
  localparam int QW   = $clog2(QMAX + 1);

  logic [1:0] loopOk;
  logic       routed;

  for (genvar g = 0; g < 2; g++) begin : g_loop
    localparam int QUAL = (g == 0) ? QUAL_L1_CYC : QUAL_L2_CYC;
    localparam logic [QW-1:0] QUAL_LIM = QW'(QUAL);

    logic          qualRun;
    logic          lockReg;
    logic [QW-1:0] elapsed;
    logic [QW-1:0] elapsedInc;

    assign elapsedInc = (elapsed < QUAL_LIM) ? elapsed + QW'(1) : elapsed;

    always_ff @(posedge clk) begin
      if (!rstN || !loopRun[g] || loopStrobe[g].outWin) begin
        qualRun <= 1'b0;
        lockReg <= 1'b0;
        elapsed <= '0;
      end else if (loopStrobe[g].inWin && !qualRun) begin
        qualRun <= 1'b1;
        elapsed <= QW'(1);
      end else if (qualRun) begin
        if (loopStrobe[g].inWin && elapsed >= QUAL_LIM) begin
          lockReg <= 1'b1;
        end
        elapsed <= elapsedInc;
      end
    end

    assign loopOk[g] = lockReg | ~loopRun[g];
  end

  always_comb begin
    unique case (testSel)
      SEL_L2_REF: routed = refPulse[1];
      SEL_L2_FB:  routed = fbPulse[1];
      SEL_L1_REF: routed = refPulse[0];
      default:    routed = fbPulse[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockOut <= 1'b0;
    end else begin
      lockOut <= testEn ? routed : (&loopOk);
    end
  end

endmodule

// File: rtl/pll_pair_lock_detect.sv
module pll_pair_lock_detect
  import pll_lockdet_pkg::*;
#(
  parameter int WINDOW_CYC  = 26,
  parameter int QUAL_L1_CYC = 412,
  parameter int QUAL_L2_CYC = 2500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loop1Ref,
  input  logic       loop1Fb,
  input  logic       loop1Run,
  input  logic       loop2Ref,
  input  logic       loop2Fb,
  input  logic       loop2Run,
  input  logic       testEn,
  input  logic [1:0] testSel,
  output logic       lockOut
);

  logic [1:0] runVec, refVec, fbVec;
  cmpStrobe_t [1:0] loopStrobe;

  assign runVec = {loop2Run, loop1Run};
  assign refVec = {loop2Ref, loop1Ref};
  assign fbVec  = {loop2Fb, loop1Fb};

  for (genvar g = 0; g < 2; g++) begin : g_ctrl
    lock_window_ctrl #(
      .WINDOW_CYC(WINDOW_CYC)
    ) u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .loopRun (runVec[g]),
      .refPulse(refVec[g]),
      .fbPulse (fbVec[g]),
      .strobe  (loopStrobe[g])
    );
  end

  lock_qual_path #(
    .QUAL_L1_CYC(QUAL_L1_CYC),
    .QUAL_L2_CYC(QUAL_L2_CYC)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .loopStrobe(loopStrobe),
    .loopRun   (runVec),
    .refPulse  (refVec),
    .fbPulse   (fbVec),
    .testEn    (testEn),
    .testSel   (testSel),
    .lockOut   (lockOut)
  );

endmodule

// File: rtl/pll_pair_lock_detect_chk.sv
module pll_pair_lock_detect_chk
  import pll_lockdet_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             loop1Ref,
  input logic             loop1Fb,
  input logic             loop1Run,
  input logic             loop2Run,
  input logic             testEn,
  input logic [1:0]       testSel,
  input logic             lockOut,
  input cmpStrobe_t [1:0] loopStrobe
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R7: the loop-1 feedback pulse is routed one cycle later
  a_r7_route_l1_fb: assert property (@(posedge clk) disable iff (!rstN)
    testEn && testSel == SEL_L1_FB |=> lockOut == $past(loop1Fb));

  // R6: both loops in power save reads as locked
  a_r6_both_asleep: assert property (@(posedge clk) disable iff (!rstN)
    !loop1Run && !loop2Run && !testEn |=> lockOut);

  // R3: a loop-1 failure reaches the pin two cycles after the strobe
  a_r3_fail_l1: assert property (@(posedge clk) disable iff (!rstN)
    loopStrobe[0].outWin && loop1Run ##1 loop1Run && !testEn |=> !lockOut);

  // R3: the same for loop 2
  a_r3_fail_l2: assert property (@(posedge clk) disable iff (!rstN)
    loopStrobe[1].outWin && loop2Run ##1 loop2Run && !testEn |=> !lockOut);

  // R2: an in-window strobe on loop 1 follows a sampled rising edge
  a_r2_pass_has_edge: assert property (@(posedge clk) disable iff (!rstN)
    sinceRst == 2'd3 && loopStrobe[0].inWin |->
      ($past(loop1Ref) && !$past(loop1Ref, 2)) || ($past(loop1Fb) && !$past(loop1Fb, 2)));

endmodule

bind pll_pair_lock_detect pll_pair_lock_detect_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loop1Ref  (loop1Ref),
  .loop1Fb   (loop1Fb),
  .loop1Run  (loop1Run),
  .loop2Run  (loop2Run),
  .testEn    (testEn),
  .testSel   (testSel),
  .lockOut   (lockOut),
  .loopStrobe(loopStrobe)
);

// File: tb/pll_pair_lock_detect_test.sv
`timescale 1ns/1ps
module pll_pair_lock_detect_test;

  localparam int WIN = 4;
  localparam int Q1  = 40;
  localparam int Q2  = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn [2];
  logic fbIn  [2];
  logic runIn [2];
  logic testEn = 1'b0;
  logic [1:0] testSel = 2'b00;
  logic lockOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pll_pair_lock_detect #(
    .WINDOW_CYC(WIN), .QUAL_L1_CYC(Q1), .QUAL_L2_CYC(Q2)
  ) uut (
    .clk(clk), .rstN(rstN),
    .loop1Ref(refIn[0]), .loop1Fb(fbIn[0]), .loop1Run(runIn[0]),
    .loop2Ref(refIn[1]), .loop2Fb(fbIn[1]), .loop2Run(runIn[1]),
    .testEn(testEn), .testSel(testSel), .lockOut(lockOut)
  );

  // Pulse generators
  bit genOn [2];
  bit fbOn  [2];
  int per   [2];
  int fbPh  [2];
  int phase [2];

  function automatic int wrapPh(int off, int p);
    int r;
    r = off % p;
    if (r < 0) r += p;
    return r;
  endfunction

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (genOn[i]) begin
        phase[i] = (phase[i] + 1) % per[i];
        refIn[i] = (phase[i] == 0);
        fbIn[i]  = fbOn[i] && (phase[i] == fbPh[i]);
      end
    end
  end

  // Port-level reference model
  int unsigned cyc;
  logic mPrevRef [2];
  logic mPrevFb  [2];
  int   mKind [2];
  int   mAge  [2];
  bit   mPass [2];
  bit   mFail [2];
  bit   mLock [2];
  bit   mRun  [2];
  int unsigned mStart [2];
  logic mOut;
  bit   mTest;
  bit   okAll, selv, re, fe, np, nf;

  function automatic int qualOf(int i);
    return (i == 0) ? Q1 : Q2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mPrevRef[i] = 1'b0; mPrevFb[i] = 1'b0; mKind[i] = 0; mAge[i] = 0;
        mPass[i] = 1'b0; mFail[i] = 1'b0; mLock[i] = 1'b0; mRun[i] = 1'b0; mStart[i] = 0;
      end
      mOut = 1'b0; mTest = 1'b0; cyc = 0;
    end else begin
      okAll = 1'b1;
      for (int i = 0; i < 2; i++) okAll = okAll & (mLock[i] | !runIn[i]);
      case (testSel)
        2'b00: selv = refIn[1];
        2'b01: selv = fbIn[1];
        2'b10: selv = refIn[0];
        default: selv = fbIn[0];
      endcase
      mOut  = testEn ? selv : okAll;
      mTest = testEn;
      for (int i = 0; i < 2; i++) begin
        if (!runIn[i] || mFail[i]) begin
          mLock[i] = 1'b0; mRun[i] = 1'b0;
        end else if (mPass[i]) begin
          if (!mRun[i]) begin
            mRun[i] = 1'b1; mStart[i] = cyc;
          end else if (cyc - mStart[i] >= qualOf(i)) begin
            mLock[i] = 1'b1;
          end
        end
      end
      for (int i = 0; i < 2; i++) begin
        re = refIn[i] && !mPrevRef[i];
        fe = fbIn[i] && !mPrevFb[i];
        mPrevRef[i] = refIn[i];
        mPrevFb[i]  = fbIn[i];
        np = 1'b0; nf = 1'b0;
        if (!runIn[i]) begin
          mKind[i] = 0; mAge[i] = 0;
        end else begin
          case (mKind[i])
            0: begin
              if (re && fe) np = 1'b1;
              else if (re) begin mKind[i] = 1; mAge[i] = 1; end
              else if (fe) begin mKind[i] = 2; mAge[i] = 1; end
            end
            1: begin
              if (fe) begin np = 1'b1; mKind[i] = re ? 1 : 0; mAge[i] = 1; end
              else if (re) begin nf = 1'b1; mAge[i] = 1; end
              else if (mAge[i] == WIN) begin nf = 1'b1; mKind[i] = 0; end
              else mAge[i] = mAge[i] + 1;
            end
            default: begin
              if (re) begin np = 1'b1; mKind[i] = fe ? 2 : 0; mAge[i] = 1; end
              else if (fe) begin nf = 1'b1; mAge[i] = 1; end
              else if (mAge[i] == WIN) begin nf = 1'b1; mKind[i] = 0; end
              else mAge[i] = mAge[i] + 1;
            end
          endcase
        end
        mPass[i] = np; mFail[i] = nf;
      end
      cyc = cyc + 1;
    end
  end

  // Continuous comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (lockOut !== mOut) begin
        errors++;
        $display("FAIL %s model compare at cycle %0d: lockOut=%b expected=%b",
                 mTest ? "R7" : "R1", cyc, lockOut, mOut);
      end
    end
  end

  task automatic expectOut(input logic exp, input string tag);
    #1;
    checks++;
    if (lockOut !== exp) begin
      errors++;
      $display("FAIL %s directed: lockOut=%b expected=%b", tag, lockOut, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLoop(input int i, input int p, input int off, input bit fbEnable);
    per[i] = p; fbPh[i] = wrapPh(off, p); fbOn[i] = fbEnable; genOn[i] = 1'b1;
    if (phase[i] >= p) phase[i] = 0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 2; i++) begin
      refIn[i] = 1'b0; fbIn[i] = 1'b0; runIn[i] = 1'b0;
      genOn[i] = 1'b0; fbOn[i] = 1'b1; per[i] = 16; fbPh[i] = 0; phase[i] = 0;
    end
    waitCyc(5);
    expectOut(1'b0, "R8");
    @(negedge clk) rstN = 1'b1;
    waitCyc(3);
    expectOut(1'b1, "R6");

    // both loops wake with aligned pulses
    runIn[0] = 1'b1; runIn[1] = 1'b1;
    setLoop(0, 16, 0, 1'b1);
    setLoop(1, 16, 0, 1'b1);
    waitCyc(3);
    expectOut(1'b0, "R6");
    waitCyc(72);
    expectOut(1'b0, "R4");
    waitCyc(125);
    expectOut(1'b1, "R1");

    // feedback late by exactly the window
    setLoop(0, 16, WIN, 1'b1);
    waitCyc(100);
    expectOut(1'b1, "R2");

    // one cycle beyond the window, late then early
    setLoop(0, 16, WIN + 1, 1'b1);
    waitCyc(40);
    expectOut(1'b0, "R3");
    setLoop(0, 16, -(WIN + 1), 1'b1);
    waitCyc(40);
    expectOut(1'b0, "R3");

    // relock only after the short qualification time
    setLoop(0, 16, 0, 1'b1);
    waitCyc(20);
    expectOut(1'b0, "R4");
    waitCyc(80);
    expectOut(1'b1, "R4");

    // repeated reference edges with no feedback
    setLoop(0, 3, 0, 1'b0);
    waitCyc(30);
    expectOut(1'b0, "R5");

    // loop 1 asleep while loop 2 stays locked
    runIn[0] = 1'b0;
    waitCyc(5);
    expectOut(1'b1, "R6");
    runIn[0] = 1'b1;
    setLoop(0, 16, 0, 1'b1);
    waitCyc(5);
    expectOut(1'b0, "R6");
    waitCyc(100);
    expectOut(1'b1, "R4");

    // test route with static levels
    genOn[0] = 1'b0; genOn[1] = 1'b0;
    refIn[0] = 1'b0; fbIn[0] = 1'b1; refIn[1] = 1'b0; fbIn[1] = 1'b1;
    testEn = 1'b1; testSel = 2'b01;
    waitCyc(2);
    expectOut(1'b1, "R7");
    testSel = 2'b00;
    waitCyc(2);
    expectOut(1'b0, "R7");
    testSel = 2'b11;
    waitCyc(2);
    expectOut(1'b1, "R7");
    testSel = 2'b10;
    waitCyc(2);
    expectOut(1'b0, "R7");
    testEn = 1'b0;
    fbIn[0] = 1'b0; fbIn[1] = 1'b0;

    // random segments checked by the model
    for (int s = 0; s < 60; s++) begin
      for (int i = 0; i < 2; i++) begin
        setLoop(i, 6 + int'($urandom_range(24)), int'($urandom_range(12)) - 6,
                ($urandom_range(9) != 0));
        runIn[i] = ($urandom_range(7) != 0);
      end
      testEn  = ($urandom_range(9) == 0);
      testSel = 2'($urandom_range(3));
      waitCyc(150 + int'($urandom_range(250)));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule